// File: doc/BRIEF.md
# Software-Filled Translation Buffer

This block is a fully associative address translation buffer whose entries are placed by software, not by a hardware walker. Software first stages the parts of a new entry in three holding registers: an effective-page register (page number, valid flag, address-space tag), a segment-attribute register (page size, protection group, guarded flag, segment valid), and an optional control register that picks the slot to fill and can fence off the lowest slots. Writing the real-page register then builds the entry from the staged values and the written real page. That write is the only event that creates an entry.

A lookup port takes an effective address and the current address-space ID. One cycle later it returns hit, the translated real address, the page size code, the protection group and the guarded flag. Each entry carries its own page size, so the compare covers only the address bits above that size. When a lookup misses, the effective-page register is loaded with the missing page number and the address-space ID, so that a refill handler can read back what was missed.

Top module: `sw_tlb`

## Requirements
- R1: After reset the result valid output is 0, the effective-page register reads 0 and every entry is invalid, so any lookup misses.
- R2: An entry is written only on a write with `wr_sel`=3 (real page). Writes with `wr_sel`=1 (effective page) or 2 (segment attribute) only stage values. The new entry is valid only when effective-page bit 9 and attribute bit 0 are both 1.
- R3: The effective-page register carries the page number in bits 31:12 and the address-space tag in bits 3:0. The attribute register carries the protection group in bits 8:5 and the guarded flag in bit 4. The entry reports these as `res_apg` and `res_guarded` on a hit.
- R4: Attribute bits 3:2 pick the page size: 11 is 8 MB, 01 is 512 KB, and 00 or 10 is a small page. For a small page, real-page write bit 3 selects 16 KB (1) or 4 KB (0). `res_size` reports 0=4 KB, 1=16 KB, 2=512 KB, 3=8 MB.
- R5: A lookup compares only the address bits at and above the entry's page size. The real address takes the entry's real page above the page size and the lookup address below it.
- R6: A lookup hits only when the entry's address-space tag equals `lk_asid`.
- R7: The result appears on the cycle after `lk_valid`. On a miss, `res_hit`, `res_addr`, `res_apg`, `res_guarded` and `res_size` are 0.
- R8: On a miss, the effective-page register becomes {missed page number, 8'h00, lookup ID} on the same edge that registers the result. A software write to that register in the same cycle takes precedence.
- R9: A control write (`wr_sel`=0) sets the fill index from bits 12:8. Each entry creation moves the index up by one, and it wraps from the last entry to entry 0.
- R10: When control bit 27 is set, entries 0 to 3 are reserved. An index that points into that range fills entry 4 instead, and the wrap after the last entry goes to entry 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control, 1 effective page, 2 segment attribute, 3 real page |
| wr_data | input | 32 | Write data |
| epn_rd | output | 32 | Current effective-page register value |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Effective address to translate |
| lk_asid | input | 4 | Current address-space ID |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup hit |
| res_addr | output | 32 | Translated real address |
| res_apg | output | 4 | Protection group of the hit entry |
| res_guarded | output | 1 | Guarded flag of the hit entry |
| res_size | output | 2 | Page size code of the hit entry |

## Verification
A lookup presented before clock edge N produces its registered result after edge N. A miss loads the effective-page register on that same edge N. A real-page write presented before edge N is visible to any lookup presented after edge N. The driver applies each stimulus at a falling edge and pushes the expected result into a queue. The monitor pops and compares at the next falling edge, when `res_valid` is high. Checks of the effective-page readback are made at that same falling edge.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;
    localparam int VPN_W = 20;
    localparam int ASID_W = 4;
    localparam int APG_W = 4;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_EPN  = 2'd1;
    localparam logic [1:0] SEL_ATTR = 2'd2;
    localparam logic [1:0] SEL_RPN  = 2'd3;

    localparam logic [1:0] SZ_4K   = 2'd0;
    localparam logic [1:0] SZ_16K  = 2'd1;
    localparam logic [1:0] SZ_512K = 2'd2;
    localparam logic [1:0] SZ_8M   = 2'd3;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  ppn;
        logic [1:0]        size;
        logic [APG_W-1:0]  apg;
        logic              guarded;
    } tlb_entry_t;

    // Mask of page-number bits that take part in the compare
    function automatic logic [VPN_W-1:0] cmp_mask(input logic [1:0] sz);
        case (sz)
            SZ_16K:  return {{(VPN_W-2){1'b1}}, 2'b0};
            SZ_512K: return {{(VPN_W-7){1'b1}}, 7'b0};
            SZ_8M:   return {{(VPN_W-11){1'b1}}, 11'b0};
            default: return {VPN_W{1'b1}};
        endcase
    endfunction
endpackage

// File: rtl/sw_tlb_stage.sv
module sw_tlb_stage
    import sw_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int RSV_COUNT   = 4,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              miss_now,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [ASID_W-1:0] miss_asid,
    output logic [31:0]       epn_q_o,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output tlb_entry_t        new_entry
);
    localparam logic [IDX_W-1:0] RSV_IDX  = IDX_W'(RSV_COUNT);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    typedef struct packed {
        logic [31:0]      epn;
        logic [31:0]      attr;
        logic [IDX_W-1:0] idx;
        logic             reserve;
    } stage_t;

    stage_t s_d, s_q;
    logic [IDX_W-1:0] eff_idx, nxt_idx;
    logic [1:0] size_code;

    always_comb begin
        s_d     = s_q;
        commit  = wr_en && (wr_sel == SEL_RPN);
        eff_idx = (s_q.reserve && s_q.idx < RSV_IDX) ? RSV_IDX : s_q.idx;
        nxt_idx = (eff_idx == LAST_IDX) ? '0 : eff_idx + 1'b1;
        if (s_q.reserve && nxt_idx < RSV_IDX) nxt_idx = RSV_IDX;
        commit_idx = eff_idx;

        case (s_q.attr[3:2])
            2'b11:   size_code = SZ_8M;
            2'b01:   size_code = SZ_512K;
            default: size_code = wr_data[3] ? SZ_16K : SZ_4K;
        endcase
        new_entry.valid   = s_q.epn[9] && s_q.attr[0];
        new_entry.vpn     = s_q.epn[31:12];
        new_entry.asid    = s_q.epn[3:0];
        new_entry.ppn     = wr_data[31:12];
        new_entry.size    = size_code;
        new_entry.apg     = s_q.attr[8:5];
        new_entry.guarded = s_q.attr[4];

        if (miss_now) s_d.epn = {miss_vpn, 8'h00, miss_asid};
        if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    s_d.idx     = wr_data[8 +: IDX_W];
                    s_d.reserve = wr_data[27];
                end
                SEL_EPN:  s_d.epn  = wr_data;
                SEL_ATTR: s_d.attr = wr_data;
                default:  s_d.idx  = nxt_idx;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign epn_q_o = s_q.epn;

    // R10: after a fill with reservation on, the index never lands in the fenced range
    a_r10_reserved_skip: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(commit) && s_q.reserve) |-> (s_q.idx >= RSV_IDX));
endmodule

// File: rtl/sw_tlb_array.sv
module sw_tlb_array
    import sw_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [IDX_W-1:0]  commit_idx,
    input  tlb_entry_t        new_entry,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              miss_now,
    output logic              res_valid,
    output logic              res_hit,
    output logic [31:0]       res_addr,
    output logic [APG_W-1:0]  res_apg,
    output logic              res_guarded,
    output logic [1:0]        res_size
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [31:0]      addr;
        logic [APG_W-1:0] apg;
        logic             guarded;
        logic [1:0]       size;
    } result_t;

    tlb_entry_t ent_d [NUM_ENTRIES];
    tlb_entry_t ent_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] hit_vec;
    result_t r_d, r_q;
    logic [IDX_W-1:0] sel;
    logic [VPN_W-1:0] msk;
    tlb_entry_t hit_ent;

    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_cmp
        assign hit_vec[gi] = ent_q[gi].valid && (ent_q[gi].asid == lk_asid) &&
            (((ent_q[gi].vpn ^ lk_addr[31:12]) & cmp_mask(ent_q[gi].size)) == '0);
    end

    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) ent_d[i] = ent_q[i];
        if (commit) ent_d[commit_idx] = new_entry;

        sel = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel = IDX_W'(i);
        end
        hit_ent  = ent_q[sel];
        msk      = cmp_mask(hit_ent.size);
        miss_now = lk_valid && (hit_vec == '0);

        r_d       = '0;
        r_d.valid = lk_valid;
        if (lk_valid && hit_vec != '0) begin
            r_d.hit     = 1'b1;
            r_d.addr    = {(hit_ent.ppn & msk) | (lk_addr[31:12] & ~msk), lk_addr[11:0]};
            r_d.apg     = hit_ent.apg;
            r_d.guarded = hit_ent.guarded;
            r_d.size    = hit_ent.size;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ent_q[i] <= '0;
            r_q <= '0;
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) ent_q[i] <= ent_d[i];
            r_q <= r_d;
        end
    end

    assign res_valid   = r_q.valid;
    assign res_hit     = r_q.hit;
    assign res_addr    = r_q.addr;
    assign res_apg     = r_q.apg;
    assign res_guarded = r_q.guarded;
    assign res_size    = r_q.size;

    // R7: every request yields a result on the next cycle
    a_r7_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    // R7: a miss carries no translation data
    a_r7_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_addr == '0 && res_apg == '0 && !res_guarded && res_size == '0));
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
    import sw_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter int RSV_COUNT   = 4,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] epn_rd,
    input  logic        lk_valid,
    input  logic [31:0] lk_addr,
    input  logic [3:0]  lk_asid,
    output logic        res_valid,
    output logic        res_hit,
    output logic [31:0] res_addr,
    output logic [3:0]  res_apg,
    output logic        res_guarded,
    output logic [1:0]  res_size
);
    logic             commit;
    logic [IDX_W-1:0] commit_idx;
    tlb_entry_t       new_entry;
    logic             miss_now;

    sw_tlb_stage #(.NUM_ENTRIES(NUM_ENTRIES), .RSV_COUNT(RSV_COUNT)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .miss_now(miss_now), .miss_vpn(lk_addr[31:12]), .miss_asid(lk_asid),
        .epn_q_o(epn_rd), .commit(commit), .commit_idx(commit_idx),
        .new_entry(new_entry)
    );

    sw_tlb_array #(.NUM_ENTRIES(NUM_ENTRIES)) u_array (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .commit_idx(commit_idx), .new_entry(new_entry),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_asid(lk_asid),
        .miss_now(miss_now),
        .res_valid(res_valid), .res_hit(res_hit), .res_addr(res_addr),
        .res_apg(res_apg), .res_guarded(res_guarded), .res_size(res_size)
    );

    // R8: a miss not overridden by software leaves the missed page and ID for readback
    a_r8_miss_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lk_valid) && res_valid && !res_hit && !$past(wr_en && wr_sel == SEL_EPN))
        |-> (epn_rd == {$past(lk_addr[31:12]), 8'h00, $past(lk_asid)}));
endmodule

// File: tb/sw_tlb_bench.sv
module sw_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] epn_rd;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic [3:0]  lk_asid = '0;
    logic        res_valid, res_hit, res_guarded;
    logic [31:0] res_addr;
    logic [3:0]  res_apg;
    logic [1:0]  res_size;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic        hit;
        logic [31:0] addr;
        logic [3:0]  apg;
        logic        guarded;
        logic [1:0]  size;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    sw_tlb u_sw_tlb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .epn_rd(epn_rd), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_asid(lk_asid),
        .res_valid(res_valid), .res_hit(res_hit), .res_addr(res_addr),
        .res_apg(res_apg), .res_guarded(res_guarded), .res_size(res_size)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per reported result
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected result", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " hit"}, {31'd0, res_hit}, {31'd0, e.hit});
                check({e.tag, " addr"}, res_addr, e.addr);
                check({e.tag, " attr"}, {25'd0, res_size, res_guarded, res_apg},
                      {25'd0, e.size, e.guarded, e.apg});
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [31:0] epn, input logic [31:0] attr, input logic [31:0] rpn);
        wr(2'd1, epn);
        wr(2'd2, attr);
        wr(2'd3, rpn);
    endtask

    task automatic look(input string tag, input logic [31:0] a, input logic [3:0] id,
                        input logic h, input logic [31:0] ra, input logic [3:0] apg,
                        input logic g, input logic [1:0] sz);
        exp_t e;
        e.hit = h; e.addr = ra; e.apg = apg; e.guarded = g; e.size = sz; e.tag = tag;
        lk_valid = 1'b1; lk_addr = a; lk_asid = id;
        exp_q.push_back(e);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic miss(input string tag, input logic [31:0] a, input logic [3:0] id);
        look(tag, a, id, 1'b0, 32'h0, 4'h0, 1'b0, 2'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 res_valid", {31'd0, res_valid}, 32'd0);
        check("R1 epn reset", epn_rd, 32'h0);
        miss("R1 empty miss", 32'h0000_0000, 4'h0);

        // R3 R4 4K entry at index 0
        load(32'h1234_5203, 32'h0000_00B1, 32'hABCD_E000);
        look("R3 4K hit", 32'h1234_5678, 4'h3, 1'b1, 32'hABCD_E678, 4'h5, 1'b1, 2'd0);
        // R6 wrong ID, R8 capture
        miss("R6 asid mismatch", 32'h1234_5678, 4'h4);
        check("R8 epn capture", epn_rd, 32'h1234_5004);

        // R4 R5 16K page at index 1
        load(32'h0000_4201, 32'h0000_0021, 32'h0080_8008);
        look("R5 16K hit", 32'h0000_7ABC, 4'h1, 1'b1, 32'h0080_BABC, 4'h1, 1'b0, 2'd1);
        // 512K at index 2
        load(32'h8000_0202, 32'h0000_0005, 32'h4000_0000);
        look("R5 512K hit", 32'h8007_FFFC, 4'h2, 1'b1, 32'h4007_FFFC, 4'h0, 1'b0, 2'd2);
        miss("R5 512K out of page", 32'h8008_0000, 4'h2);
        // 8M at index 3
        load(32'hC000_0200, 32'h0000_000D, 32'h0100_0000);
        look("R4 8M hit", 32'hC07F_FFF0, 4'h0, 1'b1, 32'h017F_FFF0, 4'h0, 1'b0, 2'd3);

        // R2 valid flags (indices 4 and 5)
        load(32'h2000_0000, 32'h0000_0001, 32'h2000_0000);
        miss("R2 epn not valid", 32'h2000_0000, 4'h0);
        load(32'h2100_0200, 32'h0000_0000, 32'h2100_0000);
        miss("R2 segment not valid", 32'h2100_0000, 4'h0);
        // R2 staging alone creates nothing
        wr(2'd1, 32'h6000_0200);
        wr(2'd2, 32'h0000_0001);
        miss("R2 no commit", 32'h6000_0000, 4'h0);

        // R10 reserve on, index 2 -> fills 4
        wr(2'd0, 32'h0800_0200);
        load(32'h3000_0200, 32'h0000_0001, 32'h5555_5000);
        look("R10 redirect fill", 32'h3000_0123, 4'h0, 1'b1, 32'h5555_5123, 4'h0, 1'b0, 2'd0);
        look("R10 entry 2 kept", 32'h8000_0010, 4'h2, 1'b1, 32'h4000_0010, 4'h0, 1'b0, 2'd2);
        // R10 wrap from 31 goes to 4
        wr(2'd0, 32'h0800_1F00);
        load(32'h3100_0200, 32'h0000_0001, 32'h5100_0000);
        load(32'h3200_0200, 32'h0000_0001, 32'h5200_0000);
        miss("R10 wrap replaced 4", 32'h3000_0123, 4'h0);
        look("R10 wrap new", 32'h3200_0044, 4'h0, 1'b1, 32'h5200_0044, 4'h0, 1'b0, 2'd0);
        look("R10 entry 0 kept", 32'h1234_5000, 4'h3, 1'b1, 32'hABCD_E000, 4'h5, 1'b1, 2'd0);

        // R9 no reserve, index 31 then wrap to 0
        wr(2'd0, 32'h0000_1F00);
        load(32'h3300_0200, 32'h0000_0001, 32'h5300_0000);
        load(32'h3400_0200, 32'h0000_0001, 32'h5400_0000);
        miss("R9 wrap replaced 0", 32'h1234_5000, 4'h3);
        look("R9 wrap new", 32'h3400_0008, 4'h0, 1'b1, 32'h5400_0008, 4'h0, 1'b0, 2'd0);
        look("R9 index 31", 32'h3300_0FFF, 4'h0, 1'b1, 32'h5300_0FFF, 4'h0, 1'b0, 2'd0);
        miss("R9 31 replaced", 32'h3100_0000, 4'h0);
        check("R8 last miss capture", epn_rd, 32'h3100_0000);

        repeat (2) @(negedge clk);
        check("R7 queue drained", exp_q.size(), 32'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule